// File: doc/BRIEF.md
# Timebase Synchronization Controller

This block sequences one core's time-base counter through alignment with a chip-level time-of-day (TOD) unit. Software drives it by writing command bits into a 64-bit control/status register. The TOD unit drives it with a sync pulse and a "TOD value delivered" strobe. The block holds the current and previous state codes, a valid flag, a sync-seen flag, a sticky firmware-control error bit, and a ready-for-TOD handshake output. It also reports writes to the time-base halves that would break synchronization.

A normal bring-up runs in this order: a load command parks the machine in the not-set state, a move command arms it, the sync pulse starts the transfer, and the TOD delivery puts the counter into the running state. Illegal command combinations and commands issued in the wrong state trap into an error state. Only a clear command leaves that state.

Top module: `tbase_sync_ctrl`

## Requirements
- R1: Register layout and state codes. State code in bits [3:0], previous state code in [7:4], valid in bit 8, sync-seen in bit 9, error in bit 10, ready-for-TOD in bit 11, pending move command in bit 17. All other bits read 0. Legal state codes are: reset 0, send 1, not-set 2, sync-wait 6, get-TOD 7, running 8, error 9. An active reset makes the whole register read 0.
- R2: A write with load (bit 16) from reset, send, not-set, sync-wait or running enters send on the next edge. A cycle with no write then moves send to not-set.
- R3: Load written in get-TOD enters error and sets the error bit.
- R4: Move (bit 17) written in not-set enters sync-wait and raises ready-for-TOD. Move written in any other state enters error, sets the error bit and drops ready.
- R5: A sync pulse in sync-wait, while move is pending, enters get-TOD.
- R6: A TOD-delivered strobe, seen in sync-wait or get-TOD, lets get-TOD enter running. Entering running clears the pending move and drops ready.
- R7: A write with load and move both set enters error and sets the error bit.
- R8: Clear (bit 18) returns the machine to reset and clears the pending move, the error bit, ready and any latched delivery.
- R9: In error, any write without clear leaves the state unchanged and sets the error bit. The one exception is a write whose only set command-field bit is bit 10.
- R10: A time-base write to the upper half (half select 1) never changes state. A lower-half write (half select 0) in running enters error. Outside running it has no effect.
- R11: Every state change copies the old code into the previous-state field. Valid is 1 exactly while the state is running.
- R12: Every register write clears sync-seen, and a sync pulse sets it. Writing 1 to bit 10 clears the error bit.
- R13: A write with load or move from a thread other than 0 leaves the state and the pending move unchanged.
- R14: In one cycle the write is applied first, then a lower-half time-base write, then the sync pulse, then TOD delivery. A move into sync-wait together with a sync pulse therefore lands in get-TOD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | DATA_W | Write data |
| thread_i | input | THR_W | Hardware thread issuing the write |
| tb_wr_i | input | 1 | Time-base half write strobe |
| tb_half_i | input | 1 | 1 = upper half, 0 = lower half |
| sync_pulse_i | input | 1 | Single-cycle sync pulse from the TOD unit |
| tod_delivered_i | input | 1 | TOD value delivered strobe |
| rd_data_o | output | DATA_W | Control register read value |
| ready_for_tod_o | output | 1 | Core ready to accept a TOD value |
| tb_valid_o | output | 1 | Time base running and valid |
| fw_err_o | output | 1 | Sticky firmware-control error |

## Verification
A wrong state code is visible in rd_data_o one edge after the stimulus that caused it. Because the previous-state field is visible too, a bad transition also shows up one transition later. A lost or spurious pending-move bit or delivery latch has no immediate effect at the ports. It first shows when a later sync pulse or TOD strobe fails to advance the machine, or advances it when it should not. The randomized stream is compared with a cycle model on every edge so that such latent faults surface.

// File: rtl/tbase_sync_pkg.sv
package tbase_sync_pkg;
  localparam int ST_LSB    = 0;
  localparam int LAST_LSB  = 4;
  localparam int VALID_BIT = 8;
  localparam int SYNC_BIT  = 9;
  localparam int ERR_BIT   = 10;
  localparam int READY_BIT = 11;
  localparam int LOAD_BIT  = 16;
  localparam int MOVE_BIT  = 17;
  localparam int CLR_BIT   = 18;
  localparam int MIN_DATA_W = CLR_BIT + 1;

  typedef enum logic [3:0] {
    ST_RESET  = 4'd0,
    ST_SEND   = 4'd1,
    ST_NOTSET = 4'd2,
    ST_SYNCW  = 4'd6,
    ST_GETTOD = 4'd7,
    ST_RUN    = 4'd8,
    ST_ERR    = 4'd9
  } tbs_st_e;

  typedef struct packed {
    tbs_st_e st;
    logic    move;
    logic    err;
    logic    dlv;
  } tbs_core_t;
endpackage

// File: rtl/tbase_sync_wr.sv
module tbase_sync_wr
  import tbase_sync_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int THR_W  = 3
) (
  input  tbs_core_t            cur_i,
  input  logic                 wr_en_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic [THR_W-1:0]     thread_i,
  output tbs_core_t            nxt_o,
  output logic                 load_acc_o
);
  logic load, move, clr, ebit, gated;
  logic wr_unused;

  assign load  = wr_data_i[LOAD_BIT];
  assign move  = wr_data_i[MOVE_BIT];
  assign clr   = wr_data_i[CLR_BIT];
  assign ebit  = wr_data_i[ERR_BIT];
  assign gated = (thread_i != '0) && (load || move);
  assign wr_unused = ^wr_data_i;

  always_comb begin
    nxt_o      = cur_i;
    load_acc_o = 1'b0;
    if (wr_en_i) begin
      if (ebit) nxt_o.err = 1'b0;
      if (!gated) begin
        nxt_o.move = move;
        if (load && move) begin
          nxt_o.st  = ST_ERR;
          nxt_o.err = 1'b1;
        end else if (clr) begin
          nxt_o.st   = ST_RESET;
          nxt_o.move = 1'b0;
          nxt_o.err  = 1'b0;
          nxt_o.dlv  = 1'b0;
        end else if (cur_i.st == ST_ERR) begin
          // lone error-bit write acknowledges without rejection
          if (load || move || !ebit) nxt_o.err = 1'b1;
        end else if (load) begin
          if (cur_i.st == ST_GETTOD) begin
            nxt_o.st  = ST_ERR;
            nxt_o.err = 1'b1;
          end else begin
            nxt_o.st   = ST_SEND;
            load_acc_o = 1'b1;
          end
        end else if (move) begin
          if (cur_i.st == ST_NOTSET) begin
            nxt_o.st = ST_SYNCW;
          end else begin
            nxt_o.st  = ST_ERR;
            nxt_o.err = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tbase_sync_evt.sv
module tbase_sync_evt
  import tbase_sync_pkg::*;
(
  input  tbs_st_e   st_q_i,
  input  tbs_core_t mid_i,
  input  logic      load_acc_i,
  input  logic      tb_lo_wr_i,
  input  logic      sync_pulse_i,
  input  logic      tod_delivered_i,
  output tbs_core_t nxt_o,
  output logic      ready_o,
  output logic      valid_o
);
  always_comb begin
    nxt_o = mid_i;
    if (nxt_o.st == ST_RUN && tb_lo_wr_i) nxt_o.st = ST_ERR;
    if (st_q_i == ST_SEND && nxt_o.st == ST_SEND && !load_acc_i) nxt_o.st = ST_NOTSET;
    if (sync_pulse_i && nxt_o.st == ST_SYNCW && nxt_o.move) nxt_o.st = ST_GETTOD;
    if (tod_delivered_i && (nxt_o.st == ST_SYNCW || nxt_o.st == ST_GETTOD)) nxt_o.dlv = 1'b1;
    if (nxt_o.st == ST_GETTOD && nxt_o.dlv) begin
      nxt_o.st   = ST_RUN;
      nxt_o.move = 1'b0;
      nxt_o.dlv  = 1'b0;
    end
    ready_o = (nxt_o.st == ST_SYNCW) || (nxt_o.st == ST_GETTOD);
    if (!ready_o) nxt_o.dlv = 1'b0;
    valid_o = (nxt_o.st == ST_RUN);
  end
endmodule

// File: rtl/tbase_sync_ctrl.sv
module tbase_sync_ctrl
  import tbase_sync_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int THR_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [THR_W-1:0]  thread_i,
  input  logic              tb_wr_i,
  input  logic              tb_half_i,
  input  logic              sync_pulse_i,
  input  logic              tod_delivered_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              ready_for_tod_o,
  output logic              tb_valid_o,
  output logic              fw_err_o
);
  tbs_core_t core_q, core_wr, core_d;
  tbs_st_e   last_q;
  logic      load_acc, ready_d, valid_d, ready_q, valid_q, sync_q;
  logic      past_ok;

  tbase_sync_wr #(.DATA_W(DATA_W), .THR_W(THR_W)) u_wr (
    .cur_i      (core_q),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .thread_i   (thread_i),
    .nxt_o      (core_wr),
    .load_acc_o (load_acc)
  );

  tbase_sync_evt u_evt (
    .st_q_i          (core_q.st),
    .mid_i           (core_wr),
    .load_acc_i      (load_acc),
    .tb_lo_wr_i      (tb_wr_i && !tb_half_i),
    .sync_pulse_i    (sync_pulse_i),
    .tod_delivered_i (tod_delivered_i),
    .nxt_o           (core_d),
    .ready_o         (ready_d),
    .valid_o         (valid_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      core_q  <= '{st: ST_RESET, move: 1'b0, err: 1'b0, dlv: 1'b0};
      last_q  <= ST_RESET;
      ready_q <= 1'b0;
      valid_q <= 1'b0;
      sync_q  <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      core_q  <= core_d;
      if (core_d.st != core_q.st) last_q <= core_q.st;
      ready_q <= ready_d;
      valid_q <= valid_d;
      sync_q  <= sync_pulse_i || (sync_q && !wr_en_i);
      past_ok <= 1'b1;
    end
  end

  always_comb begin
    rd_data_o = '0;
    rd_data_o[ST_LSB +: 4]   = core_q.st;
    rd_data_o[LAST_LSB +: 4] = last_q;
    rd_data_o[VALID_BIT]     = valid_q;
    rd_data_o[SYNC_BIT]      = sync_q;
    rd_data_o[ERR_BIT]       = core_q.err;
    rd_data_o[READY_BIT]     = ready_q;
    rd_data_o[MOVE_BIT]      = core_q.move;
  end

  assign ready_for_tod_o = ready_q;
  assign tb_valid_o      = valid_q;
  assign fw_err_o        = core_q.err;

  a_r1_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_q.st inside {ST_RESET, ST_SEND, ST_NOTSET, ST_SYNCW, ST_GETTOD, ST_RUN, ST_ERR});

  a_r2_send_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_q.st == ST_SEND && !wr_en_i) |=> (core_q.st == ST_NOTSET));

  a_r4_ready_states: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_for_tod_o |-> (core_q.st == ST_SYNCW || core_q.st == ST_GETTOD));

  a_r11_valid_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tb_valid_o == (rd_data_o[ST_LSB +: 4] == 4'd8));

  a_r11_last_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && core_q.st != $past(core_q.st)) |-> (last_q == $past(core_q.st)));

  a_r12_sync_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !sync_pulse_i) |=> !rd_data_o[SYNC_BIT]);

  a_r8_clear_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[CLR_BIT] && !wr_data_i[LOAD_BIT] && !wr_data_i[MOVE_BIT])
    |=> (core_q.st == ST_RESET && !fw_err_o));
endmodule

// File: tb/sim_tbase_sync_ctrl.sv
`timescale 1ns/1ps
module sim_tbase_sync_ctrl;
  localparam int DW = 64;
  localparam int TW = 3;
  localparam logic [DW-1:0] LD = 64'h1 << 16;
  localparam logic [DW-1:0] MV = 64'h1 << 17;
  localparam logic [DW-1:0] CL = 64'h1 << 18;
  localparam logic [DW-1:0] EB = 64'h1 << 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, wr_en, tb_wr, tb_half, sync_p, tod_d;
  logic [DW-1:0] wr_data, rd;
  logic [TW-1:0] thr;
  logic ready, valid, ferr;

  tbase_sync_ctrl #(.DATA_W(DW), .THR_W(TW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .thread_i(thr),
    .tb_wr_i(tb_wr), .tb_half_i(tb_half), .sync_pulse_i(sync_p), .tod_delivered_i(tod_d),
    .rd_data_o(rd), .ready_for_tod_o(ready), .tb_valid_o(valid), .fw_err_o(ferr)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [3:0] m_st, m_last;
  bit m_move, m_err, m_dlv, m_sync, m_ready, m_valid;

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_rd();
    logic [DW-1:0] r = '0;
    r[3:0] = m_st; r[7:4] = m_last; r[8] = m_valid; r[9] = m_sync;
    r[10] = m_err; r[11] = m_ready; r[17] = m_move;
    return r;
  endfunction

  task automatic model(bit w, logic [DW-1:0] d, logic [TW-1:0] th, bit tw, bit half, bit sy, bit td);
    logic [3:0] s = m_st;
    bit mv = m_move, er = m_err, dl = m_dlv, la = 1'b0, rdy;
    bit ld = d[16], mo = d[17], cl = d[18], eb = d[10];
    if (w) begin
      if (eb) er = 0;
      if (!(th != 0 && (ld || mo))) begin
        mv = mo;
        if (ld && mo) begin s = 9; er = 1; end
        else if (cl) begin s = 0; mv = 0; er = 0; dl = 0; end
        else if (s == 9) begin if (ld || mo || !eb) er = 1; end
        else if (ld) begin if (s == 7) begin s = 9; er = 1; end else begin s = 1; la = 1; end end
        else if (mo) begin if (s == 2) s = 6; else begin s = 9; er = 1; end end
      end
    end
    if (s == 8 && tw && !half) s = 9;
    if (m_st == 1 && s == 1 && !la) s = 2;
    if (sy && s == 6 && mv) s = 7;
    if (td && (s == 6 || s == 7)) dl = 1;
    if (s == 7 && dl) begin s = 8; mv = 0; dl = 0; end
    rdy = (s == 6 || s == 7);
    if (!rdy) dl = 0;
    if (s != m_st) m_last = m_st;
    m_st = s; m_move = mv; m_err = er; m_dlv = dl; m_ready = rdy; m_valid = (s == 8);
    m_sync = sy || (m_sync && !w);
  endtask

  task automatic step(bit w, logic [DW-1:0] d, logic [TW-1:0] th, bit tw, bit half,
                      bit sy, bit td, string tag);
    logic [DW-1:0] e;
    @(negedge clk);
    wr_en = w; wr_data = d; thr = th; tb_wr = tw; tb_half = half; sync_p = sy; tod_d = td;
    model(w, d, th, tw, half, sy, td);
    @(posedge clk); #1;
    e = exp_rd();
    chk(rd == e, tag, rd, e);
    chk({ready, valid, ferr} == {m_ready, m_valid, m_err}, tag,
        {61'd0, ready, valid, ferr}, {61'd0, m_ready, m_valid, m_err});
  endtask

  task automatic expect_st(logic [3:0] code, string tag);
    chk(rd[3:0] == code, tag, {60'd0, rd[3:0]}, {60'd0, code});
  endtask

  task automatic wr(logic [DW-1:0] d, string tag); step(1, d, 0, 0, 0, 0, 0, tag); endtask
  task automatic idle(string tag); step(0, 0, 0, 0, 0, 0, 0, tag); endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; wr_en = 0; wr_data = '0; thr = '0; tb_wr = 0; tb_half = 0; sync_p = 0; tod_d = 0;
    m_st = 0; m_last = 0; m_move = 0; m_err = 0; m_dlv = 0; m_sync = 0; m_ready = 0; m_valid = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(rd == '0, "R1 reset", rd, '0);
    chk({ready, valid, ferr} == 3'b000, "R1 reset flags", {61'd0, ready, valid, ferr}, '0);
    @(negedge clk); rst_n = 1;

    wr(LD, "R2 load");            expect_st(4'd1, "R2 send");
    idle("R2 pass");              expect_st(4'd2, "R2 notset");
    chk(rd[7:4] == 4'd1, "R11 last", {60'd0, rd[7:4]}, 64'd1);
    step(0, 0, 0, 1, 1, 0, 0, "R10 upper notset"); expect_st(4'd2, "R10");
    step(0, 0, 0, 1, 0, 0, 0, "R10 lower notset"); expect_st(4'd2, "R10");
    wr(MV, "R4 move");            expect_st(4'd6, "R4 syncw");
    chk(ready == 1'b1, "R4 ready", {63'd0, ready}, 64'd1);
    step(0, 0, 0, 0, 0, 1, 0, "R5 sync"); expect_st(4'd7, "R5 gettod");
    chk(rd[9] == 1'b1, "R12 sync seen", {63'd0, rd[9]}, 64'd1);
    step(0, 0, 0, 0, 0, 0, 1, "R6 tod"); expect_st(4'd8, "R6 run");
    chk(valid && !ready && !rd[17], "R6 flags", {61'd0, valid, ready, rd[17]}, 64'h4);
    step(0, 0, 0, 1, 1, 0, 0, "R10 upper run"); expect_st(4'd8, "R10 upper");
    step(0, 0, 0, 1, 0, 0, 0, "R10 lower run"); expect_st(4'd9, "R10 lower");
    wr('0, "R9 write in err");    chk(ferr == 1'b1, "R9 err", {63'd0, ferr}, 64'd1);
    wr(EB, "R12 w1c");            chk(ferr == 1'b0, "R12 w1c", {63'd0, ferr}, 64'd0);
    expect_st(4'd9, "R9 stays");
    wr(64'h0000_0000_0000_0020, "R9 reject"); chk(ferr == 1'b1, "R9 set", {63'd0, ferr}, 64'd1);
    wr(CL, "R8 clear");           expect_st(4'd0, "R8 reset");
    wr(LD | MV, "R7 both");       expect_st(4'd9, "R7 err");
    wr(CL, "R8 clear");
    step(1, LD, 3'd1, 0, 0, 0, 0, "R13 thread"); expect_st(4'd0, "R13 ignored");
    wr(MV, "R4 move bad");        expect_st(4'd9, "R4 err");
    wr(CL, "R8 clear");
    wr(LD, "R2"); idle("R2"); wr(MV, "R4");
    step(0, 0, 0, 0, 0, 1, 0, "R5");
    wr(LD, "R3 load gettod");     expect_st(4'd9, "R3 err");
    wr(CL, "R8 clear");
    wr(LD, "R2"); idle("R2");
    step(1, MV, 0, 0, 0, 1, 0, "R14 same cycle"); expect_st(4'd7, "R14 gettod");
    step(0, 0, 0, 0, 0, 0, 1, "R6");
    wr(LD, "R2 load run");        expect_st(4'd1, "R2 from run");
    wr(CL, "R8 clear");
    step(0, 0, 0, 0, 0, 1, 0, "R12 sync");
    wr('0, "R12 wr clears");      chk(rd[9] == 1'b0, "R12 cleared", {63'd0, rd[9]}, 64'd0);

    for (int i = 0; i < 4000; i++) begin
      logic [DW-1:0] d = {$urandom, $urandom} & ~(LD | MV | CL | EB);
      if ($urandom_range(99) < 30) d |= LD;
      if ($urandom_range(99) < 30) d |= MV;
      if ($urandom_range(99) < 8)  d |= CL;
      if ($urandom_range(99) < 30) d |= EB;
      step($urandom_range(99) < 35, d,
           ($urandom_range(99) < 85) ? 3'd0 : 3'($urandom_range(7)),
           $urandom_range(99) < 15, $urandom_range(1) == 1,
           $urandom_range(99) < 25, $urandom_range(99) < 25, "R1 random");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule